// File: doc/BRIEF.md
# Run-Time Programmable CRC-32 Register Engine

This block is a checksum engine that sits on a plain 32-bit register bus: a byte offset, a write enable, write data and registered read data. Software first loads a seed register and a generator register. It then issues a control write that copies the seed into the running accumulator. After that, every word written to the data offset is folded into the accumulator within a single clock. Reading the data offset returns the running checksum and leaves it unchanged. Software can therefore sample it after the reload and after any batch of words.

A three-bit reversal field in the control register selects reflected operation. In that mode each incoming word is mirrored across all 32 bits before the update, and the accumulator is mirrored on the way out. The update always shifts MSB-first and uses the generator exactly as written. A reflected algorithm such as the common CRC-32 or CRC-32C is therefore run by writing its normal-form generator and its mirrored seed. Software applies any final inversion itself.

Top module: `crc_regblk`

## Requirements
- R1: The register offsets (byte addresses on `bus_addr`) are: data 0x00, control 0x08, seed 0x10, generator 0x14. The seed and generator registers read back the last value written to them.
- R2: A control write with bit 0 set copies the seed register into the accumulator, and the accumulator takes that value on the same clock edge.
- R3: Reflected mode is active only while control bits 7, 6 and 5 all hold 1. Any other value of that field leaves the engine in normal mode.
- R4: After reset the seed and the accumulator are 0xFFFFFFFF, the generator is 0x04C11DB7 and the control register reads 0.
- R5: In normal mode a data write replaces accumulator C with the result of 32 steps. The steps take data bits 31 down to 0. Each step computes f = C[31] xor d, shifts C left by one, and XORs in the generator when f is 1.
- R6: The accumulator changes only on a data write or a control reload. Reads never alter it.
- R7: In reflected mode the written word is bit-mirrored before the R5 update, and a read of the data offset returns the bit-mirrored accumulator.
- R8: Control bit 0 always reads back as 0. Control bits 7 to 5 read back as written, and all other control bits read back as 0.
- R9: Writes to any other offset change no register, and reads of any other offset return 0.
- R10: `bus_rdata` is registered. It shows, one clock later, the value that the offset presented on `bus_addr` held before any write on that same edge.
- R11: In reflected mode, with seed 0xFFFFFFFF and generator 0x04C11DB7, a data write of word 0x34333231 (the ASCII bytes "1234" packed low byte first) gives a read whose inverse is 0x9BE3E0A3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (5) | Byte offset of the accessed register |
| bus_we | input | 1 | Write strobe for the offset on `bus_addr` |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's offset |

## Verification
Two functions can fall in the same cycle: a data write, and the registered read of the data offset. The bench provokes this by asserting a data write while the address already selects data. It expects the captured read to show the accumulator from before the fold, and a following read to show the folded value. A control write that sets the reload bit and the reversal field together is also issued. Its next data read is judged against the mirrored seed, which shows that the new mode and the reload both take effect on the same edge.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int CRC_W = 32;
  localparam int OFF_DATA = 'h00;
  localparam int OFF_CTRL = 'h08;
  localparam int OFF_SEED = 'h10;
  localparam int OFF_GEN  = 'h14;
  localparam int CTRL_RELOAD_BIT = 0;
  localparam int CTRL_REV_LO = 5;
  localparam int CTRL_REV_W  = 3;
  localparam logic [CRC_W-1:0] SEED_RST = 32'hFFFF_FFFF;
  localparam logic [CRC_W-1:0] GEN_RST  = 32'h04C1_1DB7;
endpackage

// File: rtl/bit_mirror.sv
module bit_mirror #(
  parameter int W = 32
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar g = 0; g < W; g++) begin : g_mir
    assign dout[g] = din[W-1-g];
  end
endmodule

// File: rtl/crc_word_fold.sv
module crc_word_fold #(
  parameter int W = 32
) (
  input  logic [W-1:0] crc_in,
  input  logic [W-1:0] word_in,
  input  logic [W-1:0] gen_in,
  output logic [W-1:0] crc_out
);
  logic [W-1:0] c;
  logic         fb;

  // Unrolled MSB-first shift/XOR chain, one step per data bit.
  always_comb begin
    c  = crc_in;
    fb = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      fb = c[W-1] ^ word_in[i];
      c  = {c[W-2:0], 1'b0} ^ ({W{fb}} & gen_in);
    end
    crc_out = c;
  end
endmodule

// File: rtl/crc_regblk.sv
module crc_regblk
  import crc_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [CRC_W-1:0]  bus_wdata,
  output logic [CRC_W-1:0]  bus_rdata
);
  localparam int REV_HI = CTRL_REV_LO + CTRL_REV_W - 1;

  logic [CRC_W-1:0]      acc_q, seed_q, gen_q;
  logic [CTRL_REV_W-1:0] rev_q;
  logic                  rev_on;
  logic [CRC_W-1:0]      wdata_mir, acc_mir, fold_in, fold_out;
  logic                  hit_data, hit_ctrl, hit_seed, hit_gen;
  logic [CRC_W-1:0]      rd_next;

  assign hit_data = (bus_addr == ADDR_W'(OFF_DATA));
  assign hit_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
  assign hit_seed = (bus_addr == ADDR_W'(OFF_SEED));
  assign hit_gen  = (bus_addr == ADDR_W'(OFF_GEN));
  assign rev_on   = &rev_q;

  bit_mirror #(.W(CRC_W)) u_mir_in  (.din(bus_wdata), .dout(wdata_mir));
  bit_mirror #(.W(CRC_W)) u_mir_out (.din(acc_q),     .dout(acc_mir));

  assign fold_in = rev_on ? wdata_mir : bus_wdata;

  crc_word_fold #(.W(CRC_W)) u_fold (
    .crc_in (acc_q),
    .word_in(fold_in),
    .gen_in (gen_q),
    .crc_out(fold_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= SEED_RST;
      seed_q <= SEED_RST;
      gen_q  <= GEN_RST;
      rev_q  <= '0;
    end else if (bus_we) begin
      if (hit_data) acc_q <= fold_out;
      if (hit_ctrl) begin
        rev_q <= bus_wdata[REV_HI:CTRL_REV_LO];
        if (bus_wdata[CTRL_RELOAD_BIT]) acc_q <= seed_q;
      end
      if (hit_seed) seed_q <= bus_wdata;
      if (hit_gen)  gen_q  <= bus_wdata;
    end
  end

  always_comb begin
    rd_next = '0;
    if (hit_data)      rd_next = rev_on ? acc_mir : acc_q;
    else if (hit_ctrl) rd_next[REV_HI:CTRL_REV_LO] = rev_q;
    else if (hit_seed) rd_next = seed_q;
    else if (hit_gen)  rd_next = gen_q;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/crc_regblk_chk.sv
module crc_regblk_chk
  import crc_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [CRC_W-1:0]  bus_wdata,
  input logic [CRC_W-1:0]  bus_rdata,
  input logic [CRC_W-1:0]  acc_q,
  input logic [CRC_W-1:0]  seed_q,
  input logic [CRC_W-1:0]  gen_q,
  input logic [2:0]        rev_q
);
  logic mapped;
  assign mapped = (bus_addr == ADDR_W'(OFF_DATA)) || (bus_addr == ADDR_W'(OFF_CTRL)) ||
                  (bus_addr == ADDR_W'(OFF_SEED)) || (bus_addr == ADDR_W'(OFF_GEN));

  AST_RELOAD_SEED: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(OFF_CTRL) && bus_wdata[0]) |=> (acc_q == $past(seed_q))); // R2

  AST_RESET_VALUES: assert property (@(posedge clk)
    rst |=> (seed_q == SEED_RST && gen_q == GEN_RST && acc_q == SEED_RST && rev_q == 3'b000)); // R4

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && (bus_addr == ADDR_W'(OFF_DATA) || bus_addr == ADDR_W'(OFF_CTRL))) |=> $stable(acc_q)); // R6

  AST_CTRL_BIT0_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(OFF_CTRL)) |=> (bus_rdata[0] == 1'b0)); // R8

  AST_UNMAPPED_WR: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !mapped) |=> ($stable(acc_q) && $stable(seed_q) && $stable(gen_q) && $stable(rev_q))); // R9

  AST_UNMAPPED_RD: assert property (@(posedge clk) disable iff (rst)
    !mapped |=> (bus_rdata == '0)); // R9
endmodule

bind crc_regblk crc_regblk_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .acc_q(acc_q), .seed_q(seed_q), .gen_q(gen_q), .rev_q(rev_q)
);

// File: tb/sim_crc_regblk.sv
`timescale 1ns/1ps
module sim_crc_regblk;
  localparam int AW = 5;
  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  crc_regblk #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [31:0] mir(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  // Normal-mode reference: bit-serial, MSB first.
  function automatic logic [31:0] ref_msb(input logic [31:0] c, input logic [31:0] w,
                                          input logic [31:0] g);
    logic [31:0] r;
    logic f;
    r = c;
    for (int i = 31; i >= 0; i--) begin
      f = r[31] ^ w[i];
      r = r << 1;
      if (f) r = r ^ g;
    end
    return r;
  endfunction

  // Reflected reference: bit-serial, LSB first, mirrored generator.
  function automatic logic [31:0] ref_lsb(input logic [31:0] c, input logic [31:0] w,
                                          input logic [31:0] rg);
    logic [31:0] r;
    r = c ^ w;
    for (int i = 0; i < 32; i++) r = r[0] ? ((r >> 1) ^ rg) : (r >> 1);
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_we = 1'b0;
    @(posedge clk);
    #1 d = bus_rdata;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
    end
  end

  initial begin
    logic [31:0] v, st, lfsr, w;
    logic [31:0] gens [4];
    gens[0] = 32'h04C11DB7; gens[1] = 32'h1EDC6F41;
    gens[2] = 32'h80000005; gens[3] = 32'h00000001;
    lfsr = 32'hACE1_2345;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R4 reset values
    rd('h00, v); chk("R4 acc", v, 32'hFFFFFFFF);
    rd('h08, v); chk("R4 ctrl", v, 32'h0);
    rd('h10, v); chk("R4 seed", v, 32'hFFFFFFFF);
    rd('h14, v); chk("R4 gen", v, 32'h04C11DB7);

    // R1 map readback
    wr('h10, 32'h1234_5678); rd('h10, v); chk("R1 seed", v, 32'h12345678);
    wr('h14, 32'h8765_4321); rd('h14, v); chk("R1 gen", v, 32'h87654321);

    // R8 control readback
    wr('h08, 32'hFFFF_FFFF); rd('h08, v); chk("R8 ctrl all", v, 32'h000000E0);
    wr('h08, 32'h0000_0040); rd('h08, v); chk("R8 ctrl partial", v, 32'h00000040);

    // R5 / R7 sweep over generators, both modes
    foreach (gens[k]) begin
      for (int m = 0; m < 2; m++) begin
        wr('h14, gens[k]);
        wr('h10, lfsr);
        wr('h08, m ? 32'h000000E1 : 32'h00000001);
        st = m ? mir(lfsr) : lfsr;
        rd('h00, v); chk(m ? "R2 R7 reload" : "R2 reload", v, st);
        for (int n = 0; n < 20; n++) begin
          lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
          w = (n < 4) ? (32'h1 << (n * 9)) : lfsr;
          wr('h00, w);
          st = m ? ref_lsb(st, w, mir(gens[k])) : ref_msb(st, w, gens[k]);
          rd('h00, v); chk(m ? "R7 reflected fold" : "R5 normal fold", v, st);
        end
        // R6 repeated reads do not disturb
        rd('h00, v); rd('h00, v); chk("R6 read stable", v, st);
      end
    end

    // R3 partial reversal field keeps normal mode
    wr('h14, 32'h04C11DB7); wr('h10, 32'h0); wr('h08, 32'h000000C1);
    wr('h00, 32'h0000_0001);
    rd('h00, v); chk("R3 partial field normal", v, ref_msb(32'h0, 32'h1, 32'h04C11DB7));

    // R9 unmapped write and read
    wr('h08, 32'h1); st = 32'h0;
    wr('h04, 32'hDEAD_BEEF); wr('h1C, 32'hDEAD_BEEF); wr('h0C, 32'h000000E1);
    rd('h00, v); chk("R9 acc untouched", v, st);
    rd('h08, v); chk("R9 ctrl untouched", v, 32'h0);
    rd('h10, v); chk("R9 seed untouched", v, 32'h0);
    rd('h14, v); chk("R9 gen untouched", v, 32'h04C11DB7);
    rd('h04, v); chk("R9 unmapped read", v, 32'h0);
    rd('h1C, v); chk("R9 unmapped read hi", v, 32'h0);

    // R10 write and read of data in the same cycle
    @(negedge clk);
    bus_addr = AW'('h00); bus_wdata = 32'hA5A5_0F0F; bus_we = 1'b1;
    @(posedge clk); #1 v = bus_rdata;
    chk("R10 same-cycle old value", v, st);
    @(negedge clk); bus_we = 1'b0;
    st = ref_msb(st, 32'hA5A50F0F, 32'h04C11DB7);
    @(posedge clk); #1 v = bus_rdata;
    chk("R10 next value", v, st);

    // R2 R7 reload and mode set together
    wr('h10, 32'h0000_00F1); wr('h08, 32'h000000E1);
    rd('h00, v); chk("R2 R7 same-edge reload", v, 32'h8F000000);

    // R11 CRC-32 of "1234"
    wr('h10, 32'hFFFF_FFFF); wr('h14, 32'h04C11DB7); wr('h08, 32'h000000E1);
    wr('h00, 32'h3433_3231);
    rd('h00, v); chk("R11 crc32 1234", ~v, 32'h9BE3E0A3);
    chk("R11 serial model", v, ref_lsb(32'hFFFFFFFF, 32'h34333231, 32'hEDB88320));

    done = 1;
    report();
  end
endmodule